// File: doc/BRIEF.md
# Daisy-Chained Bus Ownership Arbiter

This block decides which of several DMA-style requesters may drive a shared bus. The processor is the default owner. Any device that wants the bus raises its request, and the block merges all requests onto one shared request line. One cycle later a single central grant is raised at the head of a chain of per-device grant stages.

Each stage passes the grant on when its own device is idle. A stage whose device is requesting keeps the grant for itself, so position in the chain sets priority and index 0 is the highest.

A granted device takes the bus at a clock edge only when the shared busy line shows that no device owns it. In the next cycle it drives busy for as long as it holds the bus, and it gives the bus up with a one-cycle release pulse. When no device owns the bus, the processor is the owner.

Top module: `daisy_arbiter`

## Requirements
- R1: `bus_req_o` is the combinational OR of all bits of `req_i`.
- R2: `grant_o[0]` (the grant entering the head of the chain) is high in a cycle exactly when `bus_req_o` was high in the previous cycle.
- R3: For each stage i below the last, `grant_o[i+1]` is high exactly when `grant_o[i]` is high and `req_i[i]` is low. A requesting stage therefore stops the grant from reaching every stage after it.
- R4: If `grant_o[i]` and `req_i[i]` are high and `busy_o` is low at a clock edge, `own_o[i]` is high in the following cycle. When several devices request together, the lowest index wins.
- R5: While `busy_o` is high, no device that does not already own the bus gains ownership, whatever its grant and request.
- R6: At most one bit of `own_o` is high, and `busy_o` is high exactly when some bit of `own_o` is high.
- R7: A high `rel_i[i]` at an edge while `own_o[i]` is high clears `own_o[i]` in the next cycle. A `rel_i` bit of a device that does not own the bus has no effect on `own_o`.
- R8: `cpu_own_o` is high exactly when no device owns the bus.
- R9: After synchronous reset, `own_o`, `busy_o` and `grant_o[0]` are low and `cpu_own_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | N_DEV | Per-device bus request |
| rel_i | input | N_DEV | Per-device release pulse from the current owner |
| bus_req_o | output | 1 | Shared request line, the OR of all requests |
| grant_o | output | N_DEV | Grant arriving at each chain stage |
| own_o | output | N_DEV | Per-device ownership |
| busy_o | output | 1 | Shared busy line |
| cpu_own_o | output | 1 | Processor holds the bus |

## Verification
The hardest case to reach is a handover race. In the same cycle that the owner releases, a device nearer the head of the chain starts requesting while a lower-priority device is already waiting. The busy line must hold both of them off for that edge, and on the next edge the nearer device must win. Directed sequences set up this collision on purpose. Long runs of seeded random request and release patterns then produce many more overlaps of release, new requests and stale requests from the owner, and a bench model checks every output in every cycle.

// File: rtl/arb_pkg.sv
package arb_pkg;

    localparam int unsigned DEF_DEVS = 4;

    typedef enum logic {
        OWN_IDLE   = 1'b0,
        OWN_ACTIVE = 1'b1
    } own_state_e;

    typedef struct packed {
        logic grant;
        logic req;
    } chain_in_t;

    // Grant continues down the chain only past an idle device.
    function automatic logic pass_on(input chain_in_t ci);
        return ci.grant & ~ci.req;
    endfunction

    // The stage keeps the grant when its device asks for the bus.
    function automatic logic keeps(input chain_in_t ci);
        return ci.grant & ci.req;
    endfunction

endpackage

// File: rtl/arb_head.sv
module arb_head #(
    parameter int unsigned N_DEV = arb_pkg::DEF_DEVS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_DEV-1:0] req_i,
    output logic             bus_req_o,
    output logic             grant_o
);

    logic grant_q;

    assign bus_req_o = |req_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_q <= 1'b0;
        end else begin
            grant_q <= bus_req_o;
        end
    end

    assign grant_o = grant_q;

    AST_HEAD_RAISE: assert property (@(posedge clk) disable iff (rst)
        bus_req_o |=> grant_o); // R2
    AST_HEAD_DROP: assert property (@(posedge clk) disable iff (rst)
        !bus_req_o |=> !grant_o); // R2

endmodule

// File: rtl/arb_stage.sv
module arb_stage
    import arb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic grant_in,
    input  logic req_i,
    input  logic rel_i,
    input  logic busy_i,
    output logic grant_out,
    output logic own_o
);

    chain_in_t  ci;
    own_state_e state_q;
    own_state_e state_d;
    logic       hit;

    assign ci.grant  = grant_in;
    assign ci.req    = req_i;
    assign grant_out = pass_on(ci);
    assign hit       = keeps(ci);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OWN_IDLE: begin
                if (hit && !busy_i) begin
                    state_d = OWN_ACTIVE;
                end
            end
            OWN_ACTIVE: begin
                if (rel_i) begin
                    state_d = OWN_IDLE;
                end
            end
            default: state_d = OWN_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= OWN_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign own_o = (state_q == OWN_ACTIVE);

    AST_TAKE_ONLY_FREE: assert property (@(posedge clk) disable iff (rst)
        $rose(own_o) |-> ($past(!busy_i) && $past(grant_in) && $past(req_i))); // R5
    AST_TAKE_GRANTED: assert property (@(posedge clk) disable iff (rst)
        (!own_o && grant_in && req_i && !busy_i) |=> own_o); // R4
    AST_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (own_o && rel_i) |=> !own_o); // R7

endmodule

// File: rtl/daisy_arbiter.sv
module daisy_arbiter #(
    parameter int unsigned N_DEV = arb_pkg::DEF_DEVS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_DEV-1:0] req_i,
    input  logic [N_DEV-1:0] rel_i,
    output logic             bus_req_o,
    output logic [N_DEV-1:0] grant_o,
    output logic [N_DEV-1:0] own_o,
    output logic             busy_o,
    output logic             cpu_own_o
);

    localparam int unsigned CHAIN_LEN = N_DEV + 1;

    logic [CHAIN_LEN-1:0] chain;
    logic                 head_grant;

    arb_head #(.N_DEV(N_DEV)) head_i (
        .clk       (clk),
        .rst       (rst),
        .req_i     (req_i),
        .bus_req_o (bus_req_o),
        .grant_o   (head_grant)
    );

    assign chain[0] = head_grant;

    for (genvar g = 0; g < N_DEV; g++) begin : g_stage
        arb_stage stage_i (
            .clk       (clk),
            .rst       (rst),
            .grant_in  (chain[g]),
            .req_i     (req_i[g]),
            .rel_i     (rel_i[g]),
            .busy_i    (busy_o),
            .grant_out (chain[g+1]),
            .own_o     (own_o[g])
        );
    end

    assign grant_o   = chain[N_DEV-1:0];
    assign busy_o    = |own_o;
    assign cpu_own_o = ~busy_o;

    AST_ONE_OWNER: assert property (@(posedge clk) disable iff (rst)
        $onehot0(own_o)); // R6
    AST_NO_TAKE_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> ((own_o & ~$past(own_o)) == '0)); // R5

endmodule

// File: tb/daisy_arbiter_tb.sv
module daisy_arbiter_tb_top;

    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] req = '0;
    logic [N-1:0] rel = '0;
    logic         bus_req;
    logic [N-1:0] grant;
    logic [N-1:0] own;
    logic         busy;
    logic         cpu_own;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    logic [N-1:0] m_own;
    logic         m_head;

    always #10 clk = ~clk;

    daisy_arbiter #(.N_DEV(N)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .req_i     (req),
        .rel_i     (rel),
        .bus_req_o (bus_req),
        .grant_o   (grant),
        .own_o     (own),
        .busy_o    (busy),
        .cpu_own_o (cpu_own)
    );

    function automatic logic [N-1:0] exp_chain(input logic head, input logic [N-1:0] r);
        logic [N-1:0] g;
        logic         cur;
        cur = head;
        for (int i = 0; i < N; i++) begin
            g[i] = cur;
            cur  = cur & ~r[i];
        end
        return g;
    endfunction

    function automatic logic [N-1:0] exp_winner(input logic [N-1:0] g, input logic [N-1:0] r);
        for (int i = 0; i < N; i++) begin
            if (g[i] && r[i]) return N'(1) << i;
        end
        return '0;
    endfunction

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
        end
    endtask

    // Inputs are driven after a falling edge; outputs checked, model advanced at the rising edge.
    task automatic step(input logic [N-1:0] r, input logic [N-1:0] l);
        logic [N-1:0] g;
        logic [N-1:0] nxt;
        req = r;
        rel = l;
        #2;
        g = exp_chain(m_head, r);
        chk("R1 bus_req", N'(bus_req), N'(|r));
        chk("R2 head grant", N'(grant[0]), N'(m_head));
        chk("R3 chain", grant, g);
        chk("R6 busy", N'(busy), N'(|m_own));
        chk("R8 cpu_own", N'(cpu_own), N'(m_own == '0));
        chk("R4/R5/R7 own", own, m_own);
        if (m_own != '0) nxt = m_own & ~l;
        else             nxt = exp_winner(g, r);
        @(posedge clk);
        m_own  = nxt;
        m_head = |r;
        @(negedge clk);
    endtask

    initial begin : watchdog
        while (cycles < 150000 && !done) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [N-1:0] r;
        logic [N-1:0] l;
        void'($urandom(32'd1234));
        m_own  = '0;
        m_head = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #2;
        chk("R9 reset own", own, '0);
        chk("R9 reset busy", N'(busy), '0);
        chk("R9 reset grant", N'(grant[0]), '0);
        chk("R9 reset cpu_own", N'(cpu_own), N'(1));
        // R4 simultaneous requests: index 1 wins over 3
        step(4'b1010, 4'b0000);
        step(4'b1010, 4'b0000);
        chk("R4 winner is 1", own, 4'b0010);
        // R5 head device arrives while busy: held off
        step(4'b1001, 4'b0000);
        step(4'b1001, 4'b0000);
        chk("R5 no takeover while busy", own, 4'b0010);
        // R7 non-owner release ignored
        step(4'b1001, 4'b0101);
        chk("R7 non-owner release ignored", own, 4'b0010);
        // R7 owner release races with request; next edge device 0 wins
        step(4'b1001, 4'b0010);
        chk("R7 released", own, 4'b0000);
        step(4'b1001, 4'b0000);
        chk("R4 head wins after release", own, 4'b0001);
        step(4'b1000, 4'b0001);
        step(4'b1000, 4'b0000);
        chk("R4 last device owns", own, 4'b1000);
        step(4'b0000, 4'b1000);
        step(4'b0000, 4'b0000);
        chk("R8 back to processor", N'(cpu_own), N'(1));
        // Random traffic: requests drop once owning, sparse releases
        for (int k = 0; k < 4000; k++) begin
            r = N'($urandom) & N'($urandom);
            if (($urandom % 3) == 0) r = r & ~m_own;
            l = (($urandom % 4) == 0) ? N'($urandom) : '0;
            step(r, l);
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule